// File: doc/BRIEF.md
# Bus Crosstalk Class Monitor

This block watches an N-bit parallel on-chip bus and grades, for every wire, how hard the most recent word change strains it through coupling to its neighbours. Each accepted bus word is compared with the word accepted before it. Every wire gets a class from 0 to 4, built from its own transition and the transitions of the wires on either side.

The block also reports the worst class found anywhere on the bus. It raises a flag when any two adjacent wires switch in opposite directions in the same step, which is the forbidden case. The monitor is meant to sit beside a bus in simulation-friendly or on-chip debug logic, where it counts worst-case patterns or checks that an encoded bus never produces one. It does not alter the data and does not model delay.

Top module: `xtalk_class_mon`

## Requirements
- R1: While `rst` is high at a rising clock edge, `wire_class`, `max_class` and `fbd_flag` become 0 and the block forgets any earlier word.
- R2: After reset the first word accepted with `bus_valid` high only becomes the reference word. All outputs stay 0 until a second valid word arrives.
- R3: A wire's class is the sum of two side terms. A side term is 0 when the neighbour does the same thing as the wire (both steady, both rising or both falling). It is 1 when exactly one of the two switches. It is 2 when they switch in opposite directions. For the middle wire of three: 011→000 gives 1, 010→000 gives 2, 010→100 gives 3, and 010→101 gives 4.
- R4: Wire 0 has no neighbour below it and wire N-1 has none above it, so the missing side always contributes 0.
- R5: When every wire makes the same transition, for example all rising, every class is 0.
- R6: `max_class` equals the largest per-wire class of the same update.
- R7: `fbd_flag` is 1 exactly when some adjacent pair of wires goes 01→10 or 10→01 between the two compared words.
- R8: Outputs are registered and change one clock after a valid word. While `bus_valid` is low, the outputs and the reference word hold, whatever `bus_word` carries.
- R9: `wire_class` packs 3 bits per wire, with wire k in bits [3k+2:3k], so wire 0 sits in the least significant field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_word | input | BUS_W | Bus word under observation |
| bus_valid | input | 1 | High when `bus_word` carries a new word |
| wire_class | output | 3*BUS_W | Per-wire class 0..4, 3 bits per wire, wire 0 lowest |
| max_class | output | 3 | Largest per-wire class of the last update |
| fbd_flag | output | 1 | Opposite switching seen on an adjacent pair |

## Verification
The hardest condition to reach from the ports is the hold of the reference word while `bus_valid` is low. A design that wrongly loads idle data gives the same outputs as a correct one until a later valid word is compared against the wrong reference. The bench therefore drives a very different word on `bus_word` for several idle cycles. It then sends a valid word equal to the last accepted one and expects all classes to be 0. The edge-wire rules and the fourth class level need opposite switching on chosen pairs, so alternating patterns and patterns with only the two edge wires moving are applied directly.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  localparam int CLS_W = 3;

  typedef logic [CLS_W-1:0] cls_t;

  // Transition of one wire between two words.
  typedef struct packed {
    logic up;
    logic dn;
  } trans_t;

  function automatic trans_t edge_of(input logic was, input logic now);
    trans_t t;
    t.up = !was && now;
    t.dn = was && !now;
    return t;
  endfunction

  // True when the two wires switch in opposite directions.
  function automatic logic opposite(input trans_t a, input trans_t b);
    return (a.up && b.dn) || (a.dn && b.up);
  endfunction

  // Coupling cost between a wire and one neighbour: 0, 1 or 2.
  function automatic logic [1:0] side_cost(input trans_t a, input trans_t b);
    if (a == b)
      return 2'd0;
    else if (opposite(a, b))
      return 2'd2;
    else
      return 2'd1;
  endfunction
endpackage

// File: rtl/xtalk_wire_score.sv
module xtalk_wire_score
  import xtalk_pkg::*;
#(
  parameter bit HAS_LEFT  = 1'b1,
  parameter bit HAS_RIGHT = 1'b1
) (
  input  trans_t self_tr,
  input  trans_t left_tr,
  input  trans_t right_tr,
  output cls_t   cls,
  output logic   opp_right
);
  logic [1:0] raw_l, raw_r;
  logic [1:0] term_l, term_r;

  assign raw_l = side_cost(self_tr, left_tr);
  assign raw_r = side_cost(self_tr, right_tr);

  // A missing neighbour contributes nothing.
  assign term_l = HAS_LEFT  ? raw_l : 2'd0;
  assign term_r = HAS_RIGHT ? raw_r : 2'd0;

  assign cls       = cls_t'(term_l) + cls_t'(term_r);
  assign opp_right = HAS_RIGHT ? opposite(self_tr, right_tr) : 1'b0;
endmodule

// File: rtl/xtalk_max_reduce.sv
module xtalk_max_reduce
  import xtalk_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [CLS_W*N-1:0] fields,
  output cls_t               peak
);
  always_comb begin
    peak = '0;
    for (int k = 0; k < N; k++) begin
      if (fields[k*CLS_W +: CLS_W] > peak)
        peak = fields[k*CLS_W +: CLS_W];
    end
  end
endmodule

// File: rtl/xtalk_class_mon.sv
module xtalk_class_mon
  import xtalk_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [BUS_W-1:0]       bus_word,
  input  logic                   bus_valid,
  output logic [CLS_W*BUS_W-1:0] wire_class,
  output logic [CLS_W-1:0]       max_class,
  output logic                   fbd_flag
);
  localparam int VEC_W = CLS_W * BUS_W;

  logic [BUS_W-1:0] prev_q;
  logic             primed_q;
  trans_t           tr [BUS_W];
  logic [VEC_W-1:0] cls_nxt;
  logic [BUS_W-1:0] opp_vec;
  cls_t             max_nxt;

  always_comb begin
    for (int j = 0; j < BUS_W; j++)
      tr[j] = edge_of(prev_q[j], bus_word[j]);
  end

  for (genvar g = 0; g < BUS_W; g++) begin : g_wire
    trans_t lt, rt;
    if (g == 0) begin : g_lo
      assign lt = '0;
    end else begin : g_lo
      assign lt = tr[g-1];
    end
    if (g == BUS_W - 1) begin : g_hi
      assign rt = '0;
    end else begin : g_hi
      assign rt = tr[g+1];
    end

    xtalk_wire_score #(
      .HAS_LEFT  (g != 0),
      .HAS_RIGHT (g != BUS_W - 1)
    ) u_score (
      .self_tr   (tr[g]),
      .left_tr   (lt),
      .right_tr  (rt),
      .cls       (cls_nxt[g*CLS_W +: CLS_W]),
      .opp_right (opp_vec[g])
    );
  end

  xtalk_max_reduce #(.N(BUS_W)) u_max (
    .fields (cls_nxt),
    .peak   (max_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      primed_q   <= 1'b0;
      wire_class <= '0;
      max_class  <= '0;
      fbd_flag   <= 1'b0;
    end else if (bus_valid) begin
      prev_q   <= bus_word;
      primed_q <= 1'b1;
      if (primed_q) begin
        wire_class <= cls_nxt;
        max_class  <= max_nxt;
        fbd_flag   <= |opp_vec;
      end
    end
  end
endmodule

// File: rtl/xtalk_class_mon_chk.sv
module xtalk_class_mon_chk
  import xtalk_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [BUS_W-1:0]       bus_word,
  input logic                   bus_valid,
  input logic [CLS_W*BUS_W-1:0] wire_class,
  input logic [CLS_W-1:0]       max_class,
  input logic                   fbd_flag
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst)            seen_q <= 1'b0;
    else if (bus_valid) seen_q <= 1'b1;
  end

  function automatic logic peak_present(input logic [CLS_W*BUS_W-1:0] v, input cls_t m);
    logic hit;
    hit = (m == '0);
    for (int k = 0; k < BUS_W; k++)
      if (v[k*CLS_W +: CLS_W] == m) hit = 1'b1;
    return hit;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (wire_class == '0 && max_class == '0 && !fbd_flag)); // R1

  AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !seen_q) |=> (wire_class == '0 && max_class == '0 && !fbd_flag)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> ($stable(wire_class) && $stable(max_class) && $stable(fbd_flag))); // R8

  AST_FBD_SEVERE: assert property (@(posedge clk) disable iff (rst)
    fbd_flag |-> (max_class >= 3'd2)); // R7

  AST_PEAK_PRESENT: assert property (@(posedge clk) disable iff (rst)
    peak_present(wire_class, max_class)); // R6

  for (genvar g = 0; g < BUS_W; g++) begin : g_fld
    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (rst)
      wire_class[g*CLS_W +: CLS_W] <= 3'd4); // R3
    AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (rst)
      max_class >= wire_class[g*CLS_W +: CLS_W]); // R6
  end
endmodule

bind xtalk_class_mon xtalk_class_mon_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_word   (bus_word),
  .bus_valid  (bus_valid),
  .wire_class (wire_class),
  .max_class  (max_class),
  .fbd_flag   (fbd_flag)
);

// File: tb/sim_xtalk_class_mon.sv
module sim_xtalk_class_mon;
  localparam int W  = 8;
  localparam int VW = 3 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  bus_word = '0;
  logic          bus_valid = 1'b0;
  logic [VW-1:0] wire_class;
  logic [2:0]    max_class;
  logic          fbd_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [VW-1:0] exp_cls = '0;
  logic [2:0]    exp_max = '0;
  logic          exp_fbd = 1'b0;
  logic [W-1:0]  ref_word = '0;
  bit            ref_ok = 1'b0;

  always #4 clk = ~clk;

  xtalk_class_mon #(.BUS_W(W)) u0 (
    .clk(clk), .rst(rst), .bus_word(bus_word), .bus_valid(bus_valid),
    .wire_class(wire_class), .max_class(max_class), .fbd_flag(fbd_flag)
  );

  function automatic int step(input logic o, input logic n);
    return int'(n) - int'(o);
  endfunction

  function automatic int absi(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic model(input logic [W-1:0] o, input logic [W-1:0] n);
    int m;
    m = 0;
    exp_fbd = 1'b0;
    for (int j = 0; j < W; j++) begin
      int c;
      c = 0;
      if (j > 0)     c += absi(step(o[j], n[j]) - step(o[j-1], n[j-1]));
      if (j < W - 1) c += absi(step(o[j], n[j]) - step(o[j+1], n[j+1]));
      if (j < W - 1 && step(o[j], n[j]) * step(o[j+1], n[j+1]) == -1) exp_fbd = 1'b1;
      exp_cls[3*j +: 3] = 3'(c);
      if (c > m) m = c;
    end
    exp_max = 3'(m);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (wire_class !== exp_cls || max_class !== exp_max || fbd_flag !== exp_fbd) begin
      n_bad++;
      $display("FAIL %s: cls=%h max=%0d fbd=%b expected cls=%h max=%0d fbd=%b",
               tag, wire_class, max_class, fbd_flag, exp_cls, exp_max, exp_fbd);
    end
  endtask

  task automatic check_field(input string tag, input int idx, input int val);
    n_chk++;
    if (wire_class[3*idx +: 3] !== 3'(val)) begin
      n_bad++;
      $display("FAIL %s: wire %0d class=%0d expected %0d", tag, idx, wire_class[3*idx +: 3], val);
    end
  endtask

  task automatic apply(input logic [W-1:0] w);
    @(negedge clk);
    bus_word  = w;
    bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    if (ref_ok) model(ref_word, w);
    ref_word = w;
    ref_ok   = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_cls = '0; exp_max = '0; exp_fbd = 1'b0;
    ref_ok = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state");
  endtask

  task automatic t_prime();
    apply(8'hA5);
    check("R2 first word only primes");
  endtask

  task automatic t_samples();
    apply(8'h03); apply(8'h00); check("R3 011->000"); check_field("R3 011->000", 1, 1);
    apply(8'h02); apply(8'h00); check("R3 010->000"); check_field("R3 010->000", 1, 2);
    apply(8'h02); apply(8'h04); check("R3 010->100"); check_field("R3 010->100", 1, 3);
    apply(8'h02); apply(8'h05); check("R3 010->101"); check_field("R3 010->101", 1, 4);
  endtask

  task automatic t_all_rise();
    apply(8'h00); apply(8'hFF);
    check("R5 all rise");
    check_field("R5 all rise", 3, 0);
  endtask

  task automatic t_edges();
    apply(8'h00); apply(8'h81);
    check("R4 edges rise alone");
    check_field("R4 wire0", 0, 1);
    check_field("R4 wire7", 7, 1);
    apply(8'h42);
    check("R4 edges opposite inner");
    check_field("R4 wire0 opp", 0, 2);
    check_field("R4 wire7 opp", 7, 2);
  endtask

  task automatic t_forbidden();
    apply(8'h00); apply(8'h01);
    check("R7 no opposite pair");
    apply(8'h55); apply(8'hAA);
    check("R7 alternating R6 peak 4");
    apply(8'h10); apply(8'h20);
    check("R7 single pair");
  endtask

  task automatic t_idle();
    apply(8'h0F); apply(8'h3C);
    @(negedge clk);
    bus_word = 8'hC3;
    repeat (5) @(negedge clk);
    check("R8 outputs hold while idle");
    apply(8'h3C);
    check("R8 reference held while idle");
  endtask

  task automatic t_pack();
    apply(8'h00); apply(8'h01);
    n_chk++;
    if (wire_class !== 24'h000009) begin
      n_bad++;
      $display("FAIL R9 packing: cls=%h expected %h", wire_class, 24'h000009);
    end
  endtask

  task automatic t_sweep();
    logic [W-1:0] lf;
    lf = 8'h5B;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      apply(lf);
      check("R3 R6 R7 sweep");
    end
  endtask

  task automatic t_rereset();
    apply(8'h33); apply(8'hCC);
    do_reset();
    check("R1 reset after traffic");
    apply(8'hFF);
    check("R2 prime after reset");
    apply(8'h00);
    check("R5 all fall");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_prime();
    t_samples();
    t_all_rise();
    t_edges();
    t_forbidden();
    t_idle();
    t_pack();
    t_sweep();
    t_rereset();
    finish_run();
  end
endmodule